// File: doc/BRIEF.md
# I2C Write-Only Slave Receiver

This block listens on a two-wire I2C bus as a slave and accepts only master writes aimed at a 7-bit address that the host programs. SCL and SDA are brought into the system clock domain through a synchroniser. START and STOP are found from the synchronised lines. The block then shifts in an address byte, MSB first, followed by data bytes. In the ninth clock of each byte it acknowledges by raising an open-drain pull-down enable.

Every accepted byte goes into one receive register, and that includes the address byte itself. The host sees four status bits. A full bit says an unread byte is waiting. A sticky overflow bit records that a byte arrived while the register was still full; that byte is thrown away and is not acknowledged. A per-byte interrupt bit stays set until the host clears it. A R/W status bit holds the direction of the last address that matched. The host reads the register with a one-cycle strobe and clears the interrupt and overflow bits with their own one-cycle strobes.

Top module: `i2c_rx_slave`

## Requirements
- R1: After reset, `sda_oe`, `buf_full`, `rx_ovf`, `rx_irq` and `rw_bit` are 0 and `rx_data` is 0x00.
- R2: An address byte whose first seven bits (MSB first) equal `own_addr` and whose eighth bit (R/W) is 0 is acknowledged. `sda_oe` is high during the ninth SCL clock. The whole byte `{own_addr,1'b0}` is loaded into `rx_data`, and `rw_bit` becomes 0.
- R3: After an address byte that does not match, `sda_oe` is never raised. `rx_data` and all flags stay unchanged, and later bytes are ignored until the next START.
- R4: Data bytes after an acknowledged address are received MSB first, loaded into `rx_data` and acknowledged.
- R5: `buf_full` rises when a byte is loaded and falls on the clock after a `rd_en` strobe.
- R6: A byte that completes while `buf_full` is 1 sets `rx_ovf` and is not acknowledged: SDA stays released through the ninth clock. `rx_data` keeps the earlier byte.
- R7: `rx_ovf` stays 1 through reads and later good bytes. Only a `clr_ovf` strobe clears it.
- R8: `rx_irq` is set for every completed byte, including the address byte and overflowed bytes. It stays set until a `clr_irq` strobe.
- R9: An address byte that matches `own_addr` with R/W = 1 sets `rw_bit` to 1. It is not acknowledged and is not loaded.
- R10: A START (SDA falling while SCL is high) at any point restarts address reception. A STOP (SDA rising while SCL is high) returns the block to idle, and bytes that follow without a START are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as sampled |
| sda_i | input | 1 | Bus data line as sampled |
| own_addr | input | 7 | Slave address this block answers |
| rd_en | input | 1 | Host read strobe, releases the receive register |
| clr_irq | input | 1 | Host strobe clearing the interrupt bit |
| clr_ovf | input | 1 | Host strobe clearing the overflow bit |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| rx_data | output | 8 | Receive register contents |
| buf_full | output | 1 | Unread byte waiting |
| rx_ovf | output | 1 | Sticky overflow indication |
| rx_irq | output | 1 | Per-byte interrupt bit |
| rw_bit | output | 1 | R/W bit of the last matching address |

## Verification
With the default two synchroniser stages, each bus edge reaches the control logic three system clocks after it happens at the pins. The acknowledge drive therefore starts about three clocks after the eighth SCL fall and drops about three clocks after the ninth. The bench holds each SCL phase for eight clocks and reads the acknowledge at the middle of the ninth high phase. The status bits change in the same clock as the byte event, and the bench reads them a full quarter period after the ninth SCL fall. Host strobes last one clock, and their effect is checked at the falling edge that follows.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 7;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_DATA = 2'd2,
      ST_ACK  = 2'd3
   } rx_state_e;
endpackage

// File: rtl/i2c_rx_sync.sv
module i2c_rx_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '1;
            else        stg[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '1;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/i2c_rx_cond.sv
module i2c_rx_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_rx_shift.sv
module i2c_rx_shift
   import i2c_rx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              sda_s,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              buf_full,
   output logic              byte_evt,
   output logic [BYTE_W-1:0] byte_val,
   output logic              rw_evt,
   output logic              rw_val,
   output logic              sda_oe
);
   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

   rx_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] sh;
   logic              ack_q;
   logic              done, addr_hit, wr_hit;

   assign addr_hit = (sh[BYTE_W-1:1] == own_addr);
   assign wr_hit   = addr_hit & ~sh[0];
   assign done     = scl_fall & (cnt == LAST) & ~start_det & ~stop_det &
                     ((state == ST_ADDR) | (state == ST_DATA));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         sh    <= '0;
         ack_q <= 1'b0;
      end else if (start_det) begin
         state <= ST_ADDR;
         cnt   <= '0;
         ack_q <= 1'b0;
      end else if (stop_det) begin
         state <= ST_IDLE;
         cnt   <= '0;
         ack_q <= 1'b0;
      end else begin
         unique case (state)
            ST_ADDR, ST_DATA: begin
               if (scl_rise && cnt < LAST) begin
                  sh  <= {sh[BYTE_W-2:0], sda_s};
                  cnt <= cnt + CNT_W'(1);
               end else if (done) begin
                  if (state == ST_DATA || wr_hit) begin
                     state <= ST_ACK;
                     ack_q <= ~buf_full;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  state <= ST_DATA;
                  cnt   <= '0;
                  ack_q <= 1'b0;
               end
            end
            default: ;
         endcase
      end
   end

   assign byte_evt = done & ((state == ST_DATA) | wr_hit);
   assign byte_val = sh;
   assign rw_evt   = done & (state == ST_ADDR) & addr_hit;
   assign rw_val   = sh[0];
   assign sda_oe   = ack_q & (state == ST_ACK);

   p_addr_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (state == ST_ADDR && cnt == '0));
   p_ack_only_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> ($past(byte_evt) && !$past(buf_full)));
   p_idle_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> (!byte_evt && !rw_evt && !sda_oe));
endmodule

// File: rtl/i2c_rx_regs.sv
module i2c_rx_regs
   import i2c_rx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_evt,
   input  logic [BYTE_W-1:0] byte_val,
   input  logic              rw_evt,
   input  logic              rw_val,
   input  logic              rd_en,
   input  logic              clr_irq,
   input  logic              clr_ovf,
   output logic [BYTE_W-1:0] rx_data,
   output logic              full,
   output logic              ovf,
   output logic              irq,
   output logic              rw_bit
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data <= '0;
         full    <= 1'b0;
         ovf     <= 1'b0;
         irq     <= 1'b0;
         rw_bit  <= 1'b0;
      end else begin
         if (byte_evt && !full) begin
            rx_data <= byte_val;
            full    <= 1'b1;
         end else if (rd_en) begin
            full    <= 1'b0;
         end
         if (byte_evt && full) ovf <= 1'b1;
         else if (clr_ovf)     ovf <= 1'b0;
         if (byte_evt)         irq <= 1'b1;
         else if (clr_irq)     irq <= 1'b0;
         if (rw_evt)           rw_bit <= rw_val;
      end
   end

   p_load_sets_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_evt && !full) |=> (full && rx_data == $past(byte_val)));
   p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !byte_evt) |=> !full);
   p_no_overwrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_evt && full) |=> (ovf && $stable(rx_data)));
   p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr_ovf) |=> ovf);
   p_irq_per_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
      byte_evt |=> irq);
endmodule

// File: rtl/i2c_rx_slave.sv
module i2c_rx_slave
   import i2c_rx_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              rd_en,
   input  logic              clr_irq,
   input  logic              clr_ovf,
   output logic              sda_oe,
   output logic [BYTE_W-1:0] rx_data,
   output logic              buf_full,
   output logic              rx_ovf,
   output logic              rx_irq,
   output logic              rw_bit
);
   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must lie in 2..4");
   end
   if (BYTE_W != ADDR_W + 1) begin : g_bad_width
      $error("address plus R/W must fill one byte");
   end

   logic [1:0]        line_s;
   logic              scl_rise, scl_fall, start_det, stop_det;
   logic              byte_evt, rw_evt, rw_val;
   logic [BYTE_W-1:0] byte_val;

   i2c_rx_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(line_s));

   i2c_rx_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(line_s[1]), .sda_s(line_s[0]),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   i2c_rx_shift u_shift (
      .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det), .sda_s(line_s[0]),
      .own_addr(own_addr), .buf_full(buf_full), .byte_evt(byte_evt),
      .byte_val(byte_val), .rw_evt(rw_evt), .rw_val(rw_val), .sda_oe(sda_oe));

   i2c_rx_regs u_regs (
      .clk(clk), .rst_n(rst_n), .byte_evt(byte_evt), .byte_val(byte_val),
      .rw_evt(rw_evt), .rw_val(rw_val), .rd_en(rd_en), .clr_irq(clr_irq),
      .clr_ovf(clr_ovf), .rx_data(rx_data), .full(buf_full), .ovf(rx_ovf),
      .irq(rx_irq), .rw_bit(rw_bit));

   p_nack_when_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_evt && buf_full) |=> !sda_oe);
endmodule

// File: tb/i2c_rx_slave_bench.sv
`timescale 1ns/100ps
module i2c_rx_slave_bench;
   localparam int Q = 8;
   localparam logic [6:0] OWN = 7'h5A;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1, m_sda = 1'b1;
   logic       rd_en = 1'b0, clr_irq = 1'b0, clr_ovf = 1'b0;
   logic       sda_oe, buf_full, rx_ovf, rx_irq, rw_bit, sda_line;
   logic [7:0] rx_data;
   int         tests = 0, fails = 0, oe_cnt = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;
   assign sda_line = m_sda & ~sda_oe;

   i2c_rx_slave u_i2c_rx_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
      .own_addr(OWN), .rd_en(rd_en), .clr_irq(clr_irq), .clr_ovf(clr_ovf),
      .sda_oe(sda_oe), .rx_data(rx_data), .buf_full(buf_full),
      .rx_ovf(rx_ovf), .rx_irq(rx_irq), .rw_bit(rw_bit));

   always @(posedge clk) if (sda_oe) oe_cnt <= oe_cnt + 1;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic wq(); repeat (Q) @(negedge clk); endtask

   task automatic bus_start();
      m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
   endtask

   task automatic send_bit(input logic b);
      m_sda = b; wq(); m_scl = 1'b1; wq(); m_scl = 1'b0; wq();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      m_sda = 1'b1; wq(); m_scl = 1'b1;
      repeat (Q/2) @(negedge clk);
      acked = (sda_line == 1'b0);
      repeat (Q/2) @(negedge clk);
      m_scl = 1'b0; wq();
   endtask

   task automatic host_read();
      @(negedge clk) rd_en = 1'b1; @(negedge clk) rd_en = 1'b0;
   endtask
   task automatic host_clr_irq();
      @(negedge clk) clr_irq = 1'b1; @(negedge clk) clr_irq = 1'b0;
   endtask
   task automatic host_clr_ovf();
      @(negedge clk) clr_ovf = 1'b1; @(negedge clk) clr_ovf = 1'b0;
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog act=hung exp=finished");
         summary();
      end
   end

   initial begin
      logic ack;
      int   oe0;
      logic [7:0] pats [5] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81};
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 sda_oe", sda_oe, 0);
      chk("R1 full", buf_full, 0);
      chk("R1 ovf", rx_ovf, 0);
      chk("R1 irq", rx_irq, 0);
      chk("R1 rw", rw_bit, 0);
      chk("R1 data", rx_data, 0);

      // R2 / R3: sweep every 7-bit address with a write
      for (int a = 0; a < 128; a++) begin
         oe0 = oe_cnt;
         bus_start();
         send_byte({a[6:0], 1'b0}, ack);
         bus_stop();
         if (a[6:0] == OWN) begin
            chk("R2 ack", ack, 1);
            chk("R2 data", rx_data, {OWN, 1'b0});
            chk("R5 full", buf_full, 1);
            chk("R8 irq addr", rx_irq, 1);
            chk("R2 rw", rw_bit, 0);
            host_read();
            chk("R5 read clears", buf_full, 0);
            host_clr_irq();
            chk("R8 clr", rx_irq, 0);
         end else begin
            chk("R3 no ack", ack, 0);
            chk("R3 never driven", oe_cnt - oe0, 0);
            chk("R3 full", buf_full, 0);
            chk("R3 irq", rx_irq, 0);
         end
      end

      // R3: data after a foreign address is ignored
      oe0 = oe_cnt;
      bus_start();
      send_byte({7'h11, 1'b0}, ack);
      send_byte(8'h00, ack);
      chk("R3 data ignored ack", ack, 0);
      chk("R3 data ignored full", buf_full, 0);
      chk("R3 data ignored oe", oe_cnt - oe0, 0);
      chk("R3 data kept", rx_data, {OWN, 1'b0});
      bus_stop();

      // R4: data patterns
      bus_start();
      send_byte({OWN, 1'b0}, ack);
      host_read(); host_clr_irq();
      foreach (pats[i]) begin
         send_byte(pats[i], ack);
         chk("R4 ack", ack, 1);
         chk("R4 data", rx_data, pats[i]);
         chk("R5 full", buf_full, 1);
         chk("R8 irq data", rx_irq, 1);
         host_read(); host_clr_irq();
      end
      bus_stop();

      // R6 / R7: overflow
      bus_start();
      send_byte({OWN, 1'b0}, ack);
      send_byte(8'h77, ack);
      chk("R6 nack", ack, 0);
      chk("R6 ovf", rx_ovf, 1);
      chk("R6 data kept", rx_data, {OWN, 1'b0});
      chk("R8 irq ovf byte", rx_irq, 1);
      host_read(); host_clr_irq();
      chk("R7 ovf after read", rx_ovf, 1);
      send_byte(8'h12, ack);
      chk("R7 good byte ack", ack, 1);
      chk("R7 good byte data", rx_data, 8'h12);
      chk("R7 ovf still", rx_ovf, 1);
      host_clr_ovf();
      chk("R7 clr", rx_ovf, 0);
      host_read(); host_clr_irq();
      bus_stop();

      // R9: matching read address
      oe0 = oe_cnt;
      bus_start();
      send_byte({OWN, 1'b1}, ack);
      bus_stop();
      chk("R9 nack", ack, 0);
      chk("R9 rw", rw_bit, 1);
      chk("R9 not loaded", buf_full, 0);
      chk("R9 no drive", oe_cnt - oe0, 0);
      bus_start();
      send_byte({OWN, 1'b0}, ack);
      chk("R2 rw back to 0", rw_bit, 0);
      host_read(); host_clr_irq();

      // R10: repeated start mid-byte
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      bus_start();
      send_byte({OWN, 1'b0}, ack);
      chk("R10 restart ack", ack, 1);
      chk("R10 restart data", rx_data, {OWN, 1'b0});
      host_read(); host_clr_irq();
      // R10: stop mid-byte, then byte without start is ignored
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
      bus_stop();
      send_byte(8'hC3, ack);
      chk("R10 idle after stop ack", ack, 0);
      chk("R10 idle after stop full", buf_full, 0);
      chk("R10 idle after stop irq", rx_irq, 0);
      bus_stop();

      done = 1'b1;
      summary();
   end
endmodule